// File: doc/BRIEF.md
# Processor Lane Launch Controller

This block brings a cluster's virtual processors (lanes) out of halt and puts them back into it, under the control of a small register bus. It keeps a bitmap with one bit per lane that shows which lanes are currently executing. Software starts lanes by writing a bit vector to a launch command register and halts them by writing a bit vector to a halt command register. A read of the status register returns the bitmap. All three registers can be reached through two address windows that behave the same. One window is for the local cluster and the other is for another core.

A launch is a two-step handshake. The controller sends a one-cycle reset pulse to each selected lane that is idle. The lane's bit in the bitmap goes high only after that lane raises its reset-complete input. A halt sends a one-cycle halt pulse to each selected lane that is executing, and clears the lane's bit at the same edge.

After a chip reset the bitmap is zero. On the first cycle after reset is released, the controller launches the lanes named by the `START_MASK` parameter, exactly as if software had written them.

Top module: `core_launch_ctrl`

## Requirements
- R1: A write of data D to the launch register sends `vp_reset_req[i]` high for exactly one cycle, starting the cycle after the write edge, for every lane i with D[i]=1 that is idle. Lanes that are already executing or already waiting for reset completion get no pulse and keep their state.
- R2: A lane's bitmap bit becomes 1 at the edge after `vp_reset_done[i]` is sampled high while that lane waits for reset completion. `vp_reset_done` has no effect on a lane in any other state.
- R3: A write of data D to the halt register sends `vp_halt_req[i]` high for one cycle, starting the cycle after the write edge, for every executing lane i with D[i]=1. That lane's bitmap bit is 0 from the same edge onward.
- R4: A halt that selects an idle lane does nothing. A halt that selects a lane still waiting for reset completion cancels the launch without a halt pulse, and this holds even when `vp_reset_done[i]` is high in the same cycle. A later `vp_reset_done[i]` does not set that lane's bit.
- R5: For launch and halt writes, data bits at positions NUM_VP and above are ignored.
- R6: While `bus_rd` is high and the address hits a status register, `bus_rdata` shows the bitmap in bits [NUM_VP-1:0] with zeros above, in the same cycle (combinational).
- R7: The registers are decoded on a 15-bit address. Launch is at 0x2028 and 0x4028, halt is at 0x2030 and 0x4030, and status is at 0x2070 and 0x4070. Both addresses of a pair behave the same.
- R8: A read from any other address, or any cycle with `bus_rd` low, gives `bus_rdata` = 0. A write to any other address changes no state and causes no pulse.
- R9: While `rst_n` is low the bitmap reads 0 and no pulse is driven. On the first edge with `rst_n` high, the lanes set in `START_MASK` are launched as in R1. A `START_MASK` with bits at or above NUM_VP fails elaboration.
- R10: Each reset or halt pulse lasts exactly one cycle per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 15 | Register byte address |
| bus_wdata | input | 64 | Write data, one bit per lane |
| bus_rdata | output | 64 | Read data, combinational |
| vp_reset_done | input | NUM_VP | Per-lane reset-complete indication |
| vp_reset_req | output | NUM_VP | Per-lane one-cycle reset pulse |
| vp_halt_req | output | NUM_VP | Per-lane one-cycle halt pulse |

## Verification
A lane stuck in the wrong state becomes visible in one of two ways. It shows on the next status read, which is combinational. It also shows when the next launch or halt pulse appears, or fails to appear, one cycle after the command. A lane wrongly taken as executing drops its reset pulse on the following launch. A lane wrongly taken as idle sends a second reset pulse. A launch cancelled incorrectly shows as a bitmap bit that rises when the late reset-complete arrives. All of these appear within two cycles of the stimulus that exposes them, and the bench samples status before every edge.

// File: rtl/core_launch_pkg.sv
package core_launch_pkg;

  localparam int unsigned ADDR_W = 15;
  localparam int unsigned DATA_W = 64;

  // window select is address bits [14:8], register select bits [7:0]
  localparam logic [6:0] WIN_LOCAL  = 7'h20;
  localparam logic [6:0] WIN_REMOTE = 7'h40;
  localparam logic [7:0] OFS_LAUNCH = 8'h28;
  localparam logic [7:0] OFS_HALT   = 8'h30;
  localparam logic [7:0] OFS_STATUS = 8'h70;

  typedef enum logic [1:0] {
    REG_NONE,
    REG_LAUNCH,
    REG_HALT,
    REG_STATUS
  } reg_kind_e;

  typedef enum logic [1:0] {
    LANE_IDLE,
    LANE_PEND,
    LANE_EXEC
  } lane_state_e;

  function automatic reg_kind_e classify(input logic [ADDR_W-1:0] a);
    logic [6:0] win;
    logic [7:0] ofs;
    win = a[14:8];
    ofs = a[7:0];
    if (win != WIN_LOCAL && win != WIN_REMOTE) return REG_NONE;
    case (ofs)
      OFS_LAUNCH: return REG_LAUNCH;
      OFS_HALT:   return REG_HALT;
      OFS_STATUS: return REG_STATUS;
      default:    return REG_NONE;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] lane_mask(input int unsigned n);
    if (n >= DATA_W) return '1;
    return (64'd1 << n) - 64'd1;
  endfunction

endpackage

// File: rtl/launch_addr_decode.sv
module launch_addr_decode
  import core_launch_pkg::*;
(
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              launch_hit,
  output logic              halt_hit,
  output logic              status_hit
);

  reg_kind_e kind;

  always_comb begin
    kind       = classify(bus_addr);
    launch_hit = bus_wr && (kind == REG_LAUNCH);
    halt_hit   = bus_wr && (kind == REG_HALT);
    status_hit = bus_rd && (kind == REG_STATUS);
  end

endmodule

// File: rtl/launch_lane.sv
module launch_lane
  import core_launch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic launch_cmd,
  input  logic halt_cmd,
  input  logic reset_done,
  output logic executing,
  output logic reset_req,
  output logic halt_req
);

  lane_state_e state_q, state_d;
  logic        reset_req_d, halt_req_d;
  logic        pending;

  assign pending   = (state_q == LANE_PEND);
  assign executing = (state_q == LANE_EXEC);

  always_comb begin
    state_d     = state_q;
    reset_req_d = 1'b0;
    halt_req_d  = 1'b0;
    case (state_q)
      LANE_IDLE: begin
        if (launch_cmd && !halt_cmd) begin
          state_d     = LANE_PEND;
          reset_req_d = 1'b1;
        end
      end
      LANE_PEND: begin
        // halt wins over a completion arriving in the same cycle
        if (halt_cmd)        state_d = LANE_IDLE;
        else if (reset_done) state_d = LANE_EXEC;
      end
      LANE_EXEC: begin
        if (halt_cmd) begin
          state_d    = LANE_IDLE;
          halt_req_d = 1'b1;
        end
      end
      default: state_d = LANE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= LANE_IDLE;
      reset_req <= 1'b0;
      halt_req  <= 1'b0;
    end else begin
      state_q   <= state_d;
      reset_req <= reset_req_d;
      halt_req  <= halt_req_d;
    end
  end

  assert_idle_launch_pulses_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_cmd && !halt_cmd && !executing && !pending) |=> reset_req);

  assert_busy_lane_no_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (executing || pending) |=> !reset_req);

  assert_exec_needs_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(executing) |-> $past(reset_done));

  assert_halt_clears_exec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_cmd && executing) |=> (halt_req && !executing));

  assert_halt_cancels_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_cmd && pending) |=> (!pending && !executing && !halt_req));

  assert_reset_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  assert_halt_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> !halt_req);

endmodule

// File: rtl/core_launch_ctrl.sv
module core_launch_ctrl
  import core_launch_pkg::*;
#(
  parameter int unsigned       NUM_VP     = 1,
  parameter logic [DATA_W-1:0] START_MASK = 64'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_VP-1:0] vp_reset_done,
  output logic [NUM_VP-1:0] vp_reset_req,
  output logic [NUM_VP-1:0] vp_halt_req
);

  localparam logic [DATA_W-1:0] LANE_MASK = lane_mask(NUM_VP);

  initial begin : cfg_check
    assert_start_mask_fits_R9: assert ((START_MASK & ~LANE_MASK) == '0)
      else $error("START_MASK selects lanes beyond NUM_VP");
  end

  logic              launch_hit, halt_hit, status_hit;
  logic              boot_q;
  logic [NUM_VP-1:0] launch_vec, halt_vec, exec_vec;

  launch_addr_decode u_decode (
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .launch_hit (launch_hit),
    .halt_hit   (halt_hit),
    .status_hit (status_hit)
  );

  // one cycle after reset release the start set acts as a launch write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_q <= 1'b1;
    else        boot_q <= 1'b0;
  end

  assign launch_vec = NUM_VP'(((launch_hit ? bus_wdata : '0) |
                               (boot_q ? START_MASK : '0)) & LANE_MASK);
  assign halt_vec   = NUM_VP'((halt_hit ? bus_wdata : '0) & LANE_MASK);

  for (genvar i = 0; i < NUM_VP; i++) begin : g_lane
    launch_lane u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch_cmd (launch_vec[i]),
      .halt_cmd   (halt_vec[i]),
      .reset_done (vp_reset_done[i]),
      .executing  (exec_vec[i]),
      .reset_req  (vp_reset_req[i]),
      .halt_req   (vp_halt_req[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (status_hit) bus_rdata[NUM_VP-1:0] = exec_vec;
  end

  assert_unmapped_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !status_hit |-> (bus_rdata == '0));

  assert_pulses_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (vp_reset_req & vp_halt_req) == '0);

  assert_boot_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    boot_q |=> ((vp_reset_req & NUM_VP'(START_MASK)) == NUM_VP'(START_MASK)));

endmodule

// File: tb/tb_core_launch_ctrl.sv
`timescale 1ns/1ps
module tb_core_launch_ctrl;

  localparam int NV  = 21;
  localparam int NVP = 4;

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [14:0] addr;
    logic [63:0] data;
    logic [3:0]  done;
    logic [3:0]  e_rd;
    logic [3:0]  e_rst;
    logic [3:0]  e_halt;
  } vec_t;

  // wr rd addr data done | exp_rdata exp_reset exp_halt ; start state lanes 0,2 pending
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,15'h2070,64'h0,4'h5, 4'h0,4'h0,4'h0},   // 0  R2 done while pending
    '{1'b0,1'b1,15'h4070,64'h0,4'h0, 4'h5,4'h0,4'h0},   // 1  R6 R7 alias read
    '{1'b1,1'b0,15'h2028,64'hF,4'h0, 4'h0,4'hA,4'h0},   // 2  R1 only idle lanes
    '{1'b1,1'b0,15'h4028,64'h2,4'h0, 4'h0,4'h0,4'h0},   // 3  R1 R10 pending ignores
    '{1'b0,1'b1,15'h2070,64'h0,4'h2, 4'h5,4'h0,4'h0},   // 4  R2
    '{1'b0,1'b1,15'h4070,64'h0,4'h0, 4'h7,4'h0,4'h0},   // 5  R6
    '{1'b1,1'b0,15'h2030,64'h9,4'h0, 4'h0,4'h0,4'h1},   // 6  R3 R4 halt + cancel
    '{1'b0,1'b1,15'h2070,64'h0,4'h8, 4'h6,4'h0,4'h0},   // 7  R4 late done
    '{1'b0,1'b1,15'h2070,64'h0,4'h0, 4'h6,4'h0,4'h0},   // 8  R4
    '{1'b1,1'b0,15'h4030,64'hFFFF_FFF0,4'h0, 4'h0,4'h0,4'h0}, // 9  R5
    '{1'b1,1'b0,15'h2028,64'hFFFF_FFF0,4'h0, 4'h0,4'h0,4'h0}, // 10 R5
    '{1'b1,1'b0,15'h2038,64'hF,4'h0, 4'h0,4'h0,4'h0},   // 11 R8 unmapped write
    '{1'b0,1'b1,15'h0070,64'h0,4'h0, 4'h0,4'h0,4'h0},   // 12 R8 unmapped read
    '{1'b0,1'b1,15'h2070,64'h0,4'h0, 4'h6,4'h0,4'h0},   // 13 R8 no effect
    '{1'b1,1'b0,15'h2030,64'h4,4'h0, 4'h0,4'h0,4'h4},   // 14 R3
    '{1'b0,1'b1,15'h4070,64'h0,4'h0, 4'h2,4'h0,4'h0},   // 15 R3
    '{1'b1,1'b0,15'h4028,64'h9,4'h0, 4'h0,4'h9,4'h0},   // 16 R1 R7
    '{1'b1,1'b0,15'h2030,64'h1,4'h1, 4'h0,4'h0,4'h0},   // 17 R4 halt beats done
    '{1'b0,1'b1,15'h2070,64'h0,4'h8, 4'h2,4'h0,4'h0},   // 18 R2
    '{1'b0,1'b1,15'h2070,64'h0,4'h0, 4'hA,4'h0,4'h0},   // 19 R2
    '{1'b0,1'b0,15'h2070,64'h0,4'h0, 4'h0,4'h0,4'h0}    // 20 R8 rd low
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wr = 1'b0, bus_rd = 1'b0;
  logic [14:0]     bus_addr = '0;
  logic [63:0]     bus_wdata = '0;
  logic [63:0]     bus_rdata;
  logic [NVP-1:0]  vp_reset_done = '0;
  logic [NVP-1:0]  vp_reset_req, vp_halt_req;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  string vtag [NV];

  always #4 clk = ~clk;

  core_launch_ctrl #(.NUM_VP(NVP), .START_MASK(64'h5)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .vp_reset_done (vp_reset_done),
    .vp_reset_req  (vp_reset_req),
    .vp_halt_req   (vp_halt_req)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle_bus();
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0; vp_reset_done = '0;
  endtask

  // R9: reset clears status, first cycle after release launches lanes 0 and 2
  task automatic reset_and_boot();
    rst_n = 1'b0;
    idle_bus();
    bus_rd = 1'b1; bus_addr = 15'h2070;
    repeat (2) @(negedge clk);
    #1;
    chk("R9", "status in reset", bus_rdata, 64'h0);
    chk("R9", "reset_req in reset", 64'(vp_reset_req), 64'h0);
    idle_bus();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9", "reset_req before boot edge", 64'(vp_reset_req), 64'h0);
    @(negedge clk);
    chk("R9", "boot reset pulse", 64'(vp_reset_req), 64'h5);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    vtag = '{"R2","R6_R7","R1","R1_R10","R2","R6","R3_R4","R4","R4","R5","R5",
             "R8","R8","R8","R3","R3","R1_R7","R4","R2","R2","R8"};
    reset_and_boot();

    for (int v = 0; v < NV; v++) begin
      bus_wr        = TBL[v].wr;
      bus_rd        = TBL[v].rd;
      bus_addr      = TBL[v].addr;
      bus_wdata     = TBL[v].data;
      vp_reset_done = TBL[v].done;
      #1;
      chk(vtag[v], $sformatf("vec %0d rdata", v), bus_rdata, 64'(TBL[v].e_rd));
      @(negedge clk);
      chk(vtag[v], $sformatf("vec %0d reset_req", v), 64'(vp_reset_req), 64'(TBL[v].e_rst));
      chk(vtag[v], $sformatf("vec %0d halt_req", v), 64'(vp_halt_req), 64'(TBL[v].e_halt));
    end
    idle_bus();

    // R10: a single launch gives a single-cycle pulse (lane 0 idle now)
    bus_wr = 1'b1; bus_addr = 15'h2028; bus_wdata = 64'h1;
    @(negedge clk);
    idle_bus();
    chk("R10", "launch pulse first cycle", 64'(vp_reset_req), 64'h1);
    @(negedge clk);
    chk("R10", "launch pulse second cycle", 64'(vp_reset_req), 64'h0);

    // R9: mid-run reset clears everything and re-runs the boot launch
    reset_and_boot();
    @(negedge clk);
    chk("R10", "boot pulse ends", 64'(vp_reset_req), 64'h0);
    bus_rd = 1'b1; bus_addr = 15'h4070;
    #1;
    chk("R9", "status pending after boot", bus_rdata, 64'h0);
    vp_reset_done = 4'h5;
    @(negedge clk);
    vp_reset_done = '0;
    #1;
    chk("R9", "boot lanes executing", bus_rdata, 64'h5);
    idle_bus();
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule